// File: doc/BRIEF.md
# Page-wide Hamming ECC engine

This engine runs a single-error-correcting, double-error-detecting Hamming code over one whole flash page while the page streams through it, one bus word per valid beat. A start pulse chooses the page size, the bus width (8 or 16 bits) and the direction. In generate mode the engine builds a 4-byte code that the system writes into the spare area next to the data. In check mode the engine takes the same data stream, then the four stored code bytes directly after it, and gives a verdict.

The verdict sorts the page into four cases: clean, a single flipped data bit, a single flipped bit inside the stored code, or an uncorrectable pattern. For a single data error a 16-bit location gives the word address and the bit offset, and software flips that bit in its buffer. An erased page (all ones in data and code) reports as uncorrectable with a location of all ones, and software treats that pattern as clean.

Top module: `ecc_page_hamming`

## Requirements
- R1: `page_sel_i` picks 512, 1024, 2048 or 4096 data bytes for values 0, 1, 2 and 3. The page is that many bytes in 8-bit mode (`bus16_i`=0) and half as many words in 16-bit mode. In generate mode `done_o` rises exactly after the last of those beats and not before.
- R2: `code_o[15:0]` (P) is the XOR of the 16-bit value {word address[11:0], bit index[3:0]} over every set data bit. `code_o[31:16]` (N) is the XOR of the bitwise complement of that value over the same bits. Code byte k is `code_o[8k+7:8k]`.
- R3: In check mode the four stored code bytes arrive on `data_i[7:0]` on the four valid beats after the last data word, byte 0 first. The flags change only when `done_o` rises after the fourth byte.
- R4: When the stored code equals the computed code, all three flags and `err_loc_o` are zero.
- R5: A single flipped data bit gives `err_any_o`=1, `err_multi_o`=0 and `err_ecc_o`=0. `err_loc_o[3:0]` holds the bit index and `err_loc_o[15:4]` holds the word address in bus-width words.
- R6: A single flipped bit inside the four stored code bytes gives `err_any_o`=1, `err_ecc_o`=1 and `err_multi_o`=0.
- R7: Two flipped bits, whether both in data or one in data and one in the code, give `err_any_o`=1, `err_multi_o`=1 and `err_ecc_o`=0.
- R8: An erased page (all data bytes and all code bytes 0xFF) gives `err_multi_o`=1 with `err_loc_o`=16'hFFFF.
- R9: `done_o` is high for exactly one cycle, one cycle after the final beat. The flags, `err_loc_o` and `code_o` hold their values until the next start.
- R10: `start_i` clears the code, the flags, the stored bytes and the beat count, and it restarts a page even while one is in progress.
- R11: Beats with `valid_i` low, beats after the pass has finished, and `data_i[15:8]` in 8-bit mode all have no effect on `code_o` or on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a page pass and captures the configuration |
| check_i | input | 1 | 1 = check mode, 0 = generate mode |
| page_sel_i | input | 2 | Page size select |
| bus16_i | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| valid_i | input | 1 | Beat qualifier |
| data_i | input | 16 | Data word, or a code byte on bits 7:0 |
| done_o | output | 1 | One-cycle end-of-pass pulse |
| code_o | output | 32 | Computed code {N, P} |
| err_any_o | output | 1 | Any mismatch |
| err_multi_o | output | 1 | Uncorrectable pattern |
| err_ecc_o | output | 1 | Single flipped bit inside the stored code |
| err_loc_o | output | 16 | {word address, bit index} of the error |

## Verification
`code_o` includes a beat one clock edge after the edge that accepts it. `done_o`, the flags and `err_loc_o` all change on the edge that accepts the final beat, so they are due in the cycle right after that beat. The bench drives each input on a falling edge and reads the outputs on the next falling edge. That read is the exact cycle where the result is due: `done_o` must be high there, and must be low at every earlier beat and one cycle later. Extra idle beats and idle cycles then show that the results stay held.

// File: rtl/ecc_page_pkg.sv
`timescale 1ns/1ps
package ecc_page_pkg;
  localparam int ADDR_W     = 12;
  localparam int BIT_W      = 4;
  localparam int LOC_W      = ADDR_W + BIT_W;
  localparam int DATA_W     = 16;
  localparam int CODE_W     = 2 * LOC_W;
  localparam int CODE_BYTES = CODE_W / 8;
  localparam int BYTE_IDX_W = $clog2(CODE_BYTES);
  localparam int BASE_BYTES = 512;
  localparam int CNT_W      = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_CODE} phase_e;

  typedef struct packed {
    logic any;
    logic multi;
    logic ecc_only;
  } verdict_t;

  // index of the final word of a page
  function automatic logic [ADDR_W-1:0] last_word(input logic [1:0] sel, input logic bus16);
    logic [ADDR_W:0] words;
    words = (ADDR_W+1)'(BASE_BYTES) << sel;
    if (bus16) words = words >> 1;
    return ADDR_W'(words - 1'b1);
  endfunction

  // XOR of {addr, bit} over all set bits of one beat
  function automatic logic [LOC_W-1:0] beat_parity(input logic [ADDR_W-1:0] addr,
                                                  input logic [DATA_W-1:0] data,
                                                  input logic bus16);
    logic [LOC_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (data[b] && (bus16 || b < DATA_W/2)) acc ^= {addr, BIT_W'(b)};
    end
    return acc;
  endfunction

  // odd number of set bits in the active lanes
  function automatic logic beat_odd(input logic [DATA_W-1:0] data, input logic bus16);
    return bus16 ? ^data : ^data[DATA_W/2-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] popcount(input logic [CODE_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < CODE_W; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  function automatic verdict_t classify(input logic [CODE_W-1:0] stored,
                                        input logic [LOC_W-1:0] p,
                                        input logic [LOC_W-1:0] np);
    verdict_t v;
    logic [LOC_W-1:0] dp, dn;
    dp = stored[LOC_W-1:0] ^ p;
    dn = stored[CODE_W-1:LOC_W] ^ np;
    v  = '0;
    if ((dp | dn) != '0) begin
      v.any = 1'b1;
      if ((dp ^ dn) == '1) v.multi = 1'b0;
      else if (popcount({dn, dp}) == CNT_W'(1)) v.ecc_only = 1'b1;
      else v.multi = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/ecc_beat_ctrl.sv
`timescale 1ns/1ps
module ecc_beat_ctrl
  import ecc_page_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  check_i,
  input  logic [1:0]            page_sel_i,
  input  logic                  bus16_i,
  input  logic                  valid_i,
  output logic                  beat_data_o,
  output logic                  beat_code_o,
  output logic                  last_data_o,
  output logic                  last_code_o,
  output logic                  fire_last_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [BYTE_IDX_W-1:0] byte_idx_o,
  output logic                  bus16_o,
  output logic                  busy_o,
  output logic                  done_o
);
  phase_e                phase_q;
  logic [ADDR_W-1:0]     addr_q;
  logic [BYTE_IDX_W-1:0] byte_q;
  logic                  check_q;
  logic [1:0]            sel_q;
  logic                  bus16_q;
  logic                  done_q;

  assign beat_data_o = valid_i && !start_i && (phase_q == PH_DATA);
  assign beat_code_o = valid_i && !start_i && (phase_q == PH_CODE);
  assign last_data_o = beat_data_o && (addr_q == last_word(sel_q, bus16_q));
  assign last_code_o = beat_code_o && (byte_q == BYTE_IDX_W'(CODE_BYTES-1));
  assign fire_last_o = (last_data_o && !check_q) || last_code_o;
  assign addr_o      = addr_q;
  assign byte_idx_o  = byte_q;
  assign bus16_o     = bus16_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      byte_q  <= '0;
      check_q <= 1'b0;
      sel_q   <= '0;
      bus16_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= fire_last_o;
      if (start_i) begin
        phase_q <= PH_DATA;
        addr_q  <= '0;
        byte_q  <= '0;
        check_q <= check_i;
        sel_q   <= page_sel_i;
        bus16_q <= bus16_i;
      end else begin
        if (beat_data_o) addr_q <= addr_q + 1'b1;
        if (last_data_o) phase_q <= check_q ? PH_CODE : PH_IDLE;
        if (beat_code_o) byte_q <= byte_q + 1'b1;
        if (last_code_o) phase_q <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/ecc_parity_acc.sv
`timescale 1ns/1ps
module ecc_parity_acc
  import ecc_page_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              beat_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bus16_i,
  output logic [LOC_W-1:0]  p_o,
  output logic [LOC_W-1:0]  np_o
);
  logic [LOC_W-1:0] p_q, np_q;
  logic [LOC_W-1:0] contrib_w;
  logic             odd_w;

  assign contrib_w = beat_parity(addr_i, data_i, bus16_i);
  assign odd_w     = beat_odd(data_i, bus16_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q  <= '0;
      np_q <= '0;
    end else if (clear_i) begin
      p_q  <= '0;
      np_q <= '0;
    end else if (beat_i) begin
      p_q  <= p_q ^ contrib_w;
      // complement summed an odd number of times flips every bit once more
      np_q <= np_q ^ contrib_w ^ {LOC_W{odd_w}};
    end
  end

  assign p_o  = p_q;
  assign np_o = np_q;
endmodule

// File: rtl/ecc_syndrome.sv
`timescale 1ns/1ps
module ecc_syndrome
  import ecc_page_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  beat_i,
  input  logic [BYTE_IDX_W-1:0] byte_idx_i,
  input  logic [7:0]            byte_i,
  input  logic                  last_i,
  input  logic [LOC_W-1:0]      p_i,
  input  logic [LOC_W-1:0]      np_i,
  output logic                  any_o,
  output logic                  multi_o,
  output logic                  ecc_o,
  output logic [LOC_W-1:0]      loc_o
);
  logic [7:0]        lane_q [CODE_BYTES];
  logic [CODE_W-1:0] stored_next_w;
  verdict_t          verdict_w;
  verdict_t          verdict_q;
  logic [LOC_W-1:0]  loc_q;

  for (genvar k = 0; k < CODE_BYTES; k++) begin : g_lane
    logic hit_w;
    assign hit_w = beat_i && (byte_idx_i == BYTE_IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q[k] <= '0;
      else if (clear_i) lane_q[k] <= '0;
      else if (hit_w)   lane_q[k] <= byte_i;
    end
    assign stored_next_w[8*k +: 8] = hit_w ? byte_i : lane_q[k];
  end

  assign verdict_w = classify(stored_next_w, p_i, np_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= '0;
      loc_q     <= '0;
    end else if (clear_i) begin
      verdict_q <= '0;
      loc_q     <= '0;
    end else if (last_i) begin
      verdict_q <= verdict_w;
      loc_q     <= stored_next_w[LOC_W-1:0] ^ p_i;
    end
  end

  assign any_o   = verdict_q.any;
  assign multi_o = verdict_q.multi;
  assign ecc_o   = verdict_q.ecc_only;
  assign loc_o   = loc_q;
endmodule

// File: rtl/ecc_page_hamming.sv
`timescale 1ns/1ps
module ecc_page_hamming
  import ecc_page_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              check_i,
  input  logic [1:0]        page_sel_i,
  input  logic              bus16_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic              err_any_o,
  output logic              err_multi_o,
  output logic              err_ecc_o,
  output logic [LOC_W-1:0]  err_loc_o
);
  logic                  beat_data_w, beat_code_w;
  logic                  last_data_w, last_code_w, fire_last_w;
  logic [ADDR_W-1:0]     addr_w;
  logic [BYTE_IDX_W-1:0] byte_idx_w;
  logic                  bus16_w, busy_w;
  logic [LOC_W-1:0]      p_w, np_w;

  ecc_beat_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .check_i(check_i),
    .page_sel_i(page_sel_i), .bus16_i(bus16_i), .valid_i(valid_i),
    .beat_data_o(beat_data_w), .beat_code_o(beat_code_w),
    .last_data_o(last_data_w), .last_code_o(last_code_w),
    .fire_last_o(fire_last_w), .addr_o(addr_w), .byte_idx_o(byte_idx_w),
    .bus16_o(bus16_w), .busy_o(busy_w), .done_o(done_o)
  );

  ecc_parity_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .beat_i(beat_data_w),
    .addr_i(addr_w), .data_i(data_i), .bus16_i(bus16_w),
    .p_o(p_w), .np_o(np_w)
  );

  ecc_syndrome u_syn (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .beat_i(beat_code_w),
    .byte_idx_i(byte_idx_w), .byte_i(data_i[7:0]), .last_i(last_code_w),
    .p_i(p_w), .np_i(np_w),
    .any_o(err_any_o), .multi_o(err_multi_o), .ecc_o(err_ecc_o), .loc_o(err_loc_o)
  );

  assign code_o = {np_w, p_w};
endmodule

// File: rtl/ecc_page_hamming_chk.sv
`timescale 1ns/1ps
module ecc_page_hamming_chk
  import ecc_page_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              done_o,
  input logic              busy_w,
  input logic              fire_last_w,
  input logic [CODE_W-1:0] code_o,
  input logic              err_any_o,
  input logic              err_multi_o,
  input logic              err_ecc_o,
  input logic [LOC_W-1:0]  err_loc_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_LAST_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last_w |=> (done_o && !busy_w)); // R9
  AST_MULTI_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    err_multi_o |-> err_any_o); // R7
  AST_ECC_IS_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    err_ecc_o |-> (err_any_o && !err_multi_o)); // R6
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any_o) |-> done_o); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (code_o == '0 && !err_any_o && !done_o)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !start_i) |=> ($stable(code_o) && $stable(err_loc_o))); // R11
endmodule

bind ecc_page_hamming ecc_page_hamming_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
  .busy_w(busy_w), .fire_last_w(fire_last_w), .code_o(code_o),
  .err_any_o(err_any_o), .err_multi_o(err_multi_o), .err_ecc_o(err_ecc_o),
  .err_loc_o(err_loc_o)
);

// File: tb/ecc_page_hamming_tb.sv
`timescale 1ns/1ps
module ecc_page_hamming_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start_i = 1'b0, check_i = 1'b0, bus16_i = 1'b0, valid_i = 1'b0;
  logic [1:0]  page_sel_i = 2'd0;
  logic [15:0] data_i = '0;
  logic        done_o, err_any_o, err_multi_o, err_ecc_o;
  logic [31:0] code_o;
  logic [15:0] err_loc_o;

  int n_checks = 0, n_errs = 0;
  bit finished = 0;
  logic [15:0] pg [0:4095];

  always #2.5 clk = ~clk;

  ecc_page_hamming u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .check_i(check_i),
    .page_sel_i(page_sel_i), .bus16_i(bus16_i), .valid_i(valid_i), .data_i(data_i),
    .done_o(done_o), .code_o(code_o), .err_any_o(err_any_o),
    .err_multi_o(err_multi_o), .err_ecc_o(err_ecc_o), .err_loc_o(err_loc_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int words(input logic [1:0] sel, input bit b16);
    return (512 << sel) >> b16;
  endfunction

  // code from the definition: per set bit, fold in {addr,bit} and its complement
  function automatic logic [31:0] ref_code(input int n, input bit b16);
    logic [15:0] p = '0, q = '0;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < (b16 ? 16 : 8); b++)
        if (pg[i][b]) begin
          logic [15:0] x;
          x = 16'((i << 4) | b);
          p ^= x;
          q ^= ~x;
        end
    return {q, p};
  endfunction

  task automatic fill(input bit erased);
    for (int i = 0; i < 4096; i++) pg[i] = erased ? 16'hFFFF : 16'($urandom);
  endtask

  task automatic beat(input logic [15:0] d);
    valid_i = 1'b1; data_i = d;
    @(negedge clk);
    valid_i = 1'b0; data_i = 16'($urandom);
  endtask

  task automatic pulse_start(input bit chk, input logic [1:0] sel, input bit b16);
    start_i = 1'b1; check_i = chk; page_sel_i = sel; bus16_i = b16;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one complete pass; checks done timing
  task automatic run_page(input string req, input bit chk, input logic [1:0] sel,
                          input bit b16, input bit gaps, input logic [31:0] stored);
    int n = words(sel, b16);
    int early = 0;
    logic [15:0] j;
    pulse_start(chk, sel, b16);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 7) == 3) begin
        valid_i = 1'b0; data_i = 16'($urandom); @(negedge clk);
      end
      j = 16'($urandom);
      beat(b16 ? pg[i] : {j[15:8], pg[i][7:0]});
      if ((i != n-1 || chk) && done_o) early++;
    end
    if (chk)
      for (int k = 0; k < 4; k++) begin
        j = 16'($urandom);
        beat({j[15:8], stored[8*k +: 8]});
        if (k < 3 && done_o) early++;
      end
    check(req, "done due after final beat", 32'(done_o), 32'd1);
    check(req, "no early done", 32'(early), 32'd0);
    @(negedge clk);
    check("R9", "done lasts one cycle", 32'(done_o), 32'd0);
  endtask

  task automatic flags(input string req, input bit a, input bit m, input bit e);
    check(req, "flags {any,multi,ecc}", {29'd0, err_any_o, err_multi_o, err_ecc_o},
          {29'd0, a, m, e});
  endtask

  initial begin
    logic [31:0] good, held;
    repeat (3) @(negedge clk);
    check("R9", "reset done", 32'(done_o), 32'd0);
    check("R4", "reset flags", {29'd0, err_any_o, err_multi_o, err_ecc_o}, 32'd0);
    check("R2", "reset code", code_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: every page size, both widths, generate mode
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
        fill(0);
        run_page("R1", 1'b0, 2'(s), w[0], 1'b0, '0);
        check("R2", $sformatf("code sel=%0d b16=%0d", s, w), code_o, ref_code(words(2'(s), w[0]), w[0]));
      end

    // R11: gaps and junk upper byte in 8-bit mode
    fill(0);
    run_page("R11", 1'b0, 2'd1, 1'b0, 1'b1, '0);
    good = ref_code(1024, 1'b0);
    check("R11", "gaps and upper byte ignored", code_o, good);
    held = code_o;
    repeat (8) beat(16'($urandom));
    check("R11", "beats while idle ignored", code_o, held);
    check("R11", "no done from idle beats", 32'(done_o), 32'd0);

    // R10: restart in the middle of a page
    fill(0);
    pulse_start(1'b0, 2'd0, 1'b0);
    repeat (50) beat(16'($urandom));
    run_page("R10", 1'b0, 2'd0, 1'b0, 1'b0, '0);
    check("R10", "restart mid page", code_o, ref_code(512, 1'b0));

    // R3 R4: clean check, both widths
    for (int w = 0; w < 2; w++) begin
      fill(0);
      good = ref_code(words(2'd0, w[0]), w[0]);
      run_page("R3", 1'b1, 2'd0, w[0], w[0], good);
      flags("R4", 1'b0, 1'b0, 1'b0);
      check("R4", "clean location", 32'(err_loc_o), 32'd0);
    end

    // R5: single data bit, every bit index, 16-bit words
    for (int b = 0; b < 16; b++) begin
      int a = (b * 17 + 3) % 256;
      fill(0);
      good = ref_code(256, 1'b1);
      pg[a][b] = ~pg[a][b];
      run_page("R5", 1'b1, 2'd0, 1'b1, 1'b0, good);
      flags("R5", 1'b1, 1'b0, 1'b0);
      check("R5", "location 16-bit", 32'(err_loc_o), 32'((a << 4) | b));
    end
    // R5: 8-bit words, including first and last address
    for (int b = 0; b < 8; b++) begin
      int a = (b == 0) ? 0 : (b == 7) ? 511 : b * 61;
      fill(0);
      good = ref_code(512, 1'b0);
      pg[a][b] = ~pg[a][b];
      run_page("R5", 1'b1, 2'd0, 1'b0, 1'b0, good);
      flags("R5", 1'b1, 1'b0, 1'b0);
      check("R5", "location 8-bit", 32'(err_loc_o), 32'((a << 4) | b));
    end
    // R5: top of the 12-bit word field
    fill(0);
    good = ref_code(4096, 1'b0);
    pg[4095][6] = ~pg[4095][6];
    run_page("R5", 1'b1, 2'd3, 1'b0, 1'b0, good);
    flags("R5", 1'b1, 1'b0, 1'b0);
    check("R5", "location word 4095", 32'(err_loc_o), 32'hFFF6);

    // R6: each of the 32 code bits flipped
    fill(0);
    good = ref_code(256, 1'b1);
    for (int k = 0; k < 32; k++) begin
      run_page("R6", 1'b1, 2'd0, 1'b1, 1'b0, good ^ (32'd1 << k));
      flags("R6", 1'b1, 1'b0, 1'b1);
    end
    // R9: verdict held through idle beats
    repeat (5) beat(16'($urandom));
    flags("R9", 1'b1, 1'b0, 1'b1);

    // R7: two data bits; one data bit plus one code bit
    fill(0);
    good = ref_code(512, 1'b0);
    pg[10][3] = ~pg[10][3];
    pg[200][7] = ~pg[200][7];
    run_page("R7", 1'b1, 2'd0, 1'b0, 1'b0, good);
    flags("R7", 1'b1, 1'b1, 1'b0);
    fill(0);
    good = ref_code(256, 1'b1);
    pg[5][1] = ~pg[5][1];
    run_page("R7", 1'b1, 2'd0, 1'b1, 1'b0, good ^ 32'h0010_0000);
    flags("R7", 1'b1, 1'b1, 1'b0);

    // R10: start alone clears verdict and code
    pulse_start(1'b1, 2'd0, 1'b0);
    check("R10", "code cleared", code_o, 32'd0);
    flags("R10", 1'b0, 1'b0, 1'b0);

    // R8: erased pages
    fill(1);
    run_page("R8", 1'b1, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF);
    flags("R8", 1'b1, 1'b1, 1'b0);
    check("R8", "erased location 8-bit", 32'(err_loc_o), 32'h0000_FFFF);
    run_page("R8", 1'b1, 2'd1, 1'b1, 1'b0, 32'hFFFF_FFFF);
    flags("R8", 1'b1, 1'b1, 1'b0);
    check("R8", "erased location 16-bit", 32'(err_loc_o), 32'h0000_FFFF);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    #750000;
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end
endmodule